// File: doc/BRIEF.md
# Per-Target Address History Resolver

This block expands the compact address forms of a serial service link into full addresses. A frame decoder hands it one request at a time: the target ID, the command kind, the raw address field, a sign bit for relative offsets and the transfer-size bit. The block looks up the last confirmed address for that target and produces a full address. It also decodes the transfer size from the low bits of the received field, forces the alignment bits that the size demands, and raises a flag when a relative or same-address form arrives with no base on record.

After the target has answered, the decoder sends a commit strobe carrying the CRC verdict and the response code. A clean acknowledge writes the most recently resolved address into that target's history slot. A link break wipes all history. Results appear one clock after the request, on registered outputs.

Top module: `addr_hist_resolver`

## Requirements
- R1: An absolute request (cmd code 0, or the spare code 3) yields the full received address field, and the missing-base flag stays low.
- R2: A same-address request (cmd code 2) with a valid base yields the stored address with its two lowest bits replaced by raw[1:0].
- R3: A relative request (cmd code 1) with sign 0 yields the stored address plus raw[7:0], wrapping modulo 2^21.
- R4: A relative request with sign 1 yields the stored address minus (256 - raw[7:0]), wrapping modulo 2^21.
- R5: A relative or same-address request whose target has no valid base sets the missing-base flag and yields the field value zero-extended (raw[7:0] for relative, raw[1:0] for same-address).
- R6: A commit (commit response 0 = ACK or 1 = ACK with data; 2 = busy, 3 = address error, 4 = CRC error) stores the last resolved address for its target only when the CRC-good bit is 1 and the response is 0 or 1. Any other commit leaves the history unchanged.
- R7: Size bit 0 reports byte (size code 0) and leaves the address unforced.
- R8: Size bit 1 with raw[1:0] = 01 reports word (code 2), and the resolved address has bits [1:0] forced to 01.
- R9: Size bit 1 with raw[0] = 0 reports half-word (code 1), and the resolved address has bit 0 forced to 0.
- R10: Size bit 1 with raw[1:0] = 11 reports unknown (code 3), the address goes out unforced, and the resolution is not eligible for storage: a following commit stores nothing.
- R11: A break pulse invalidates the history of every target.
- R12: Outputs are registered. out_valid pulses high exactly one cycle after each request, and a synchronous reset clears the outputs and all history.
- R13: Each target keeps its own history, and a store for one target does not change another target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| brk_clr | input | 1 | Link break: invalidate all history |
| req_valid | input | 1 | Resolve request strobe |
| req_tid | input | 2 | Target ID of the request |
| req_cmd | input | 2 | Command kind: 0 absolute, 1 relative, 2 same-address, 3 treated as absolute |
| req_raw | input | 21 | Received address field, right-aligned |
| req_neg | input | 1 | Sign of a relative offset (1 = negative) |
| req_szb | input | 1 | Transfer-size bit |
| cmt_valid | input | 1 | Commit strobe after the target answered |
| cmt_crc_ok | input | 1 | CRC of the exchange was good |
| cmt_resp | input | 3 | Response code: 0 ACK, 1 ACK with data, 2 busy, 3 address error, 4 CRC error |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_addr | output | 21 | Resolved and alignment-forced address |
| out_nobase | output | 1 | Relative or same-address form had no valid base |
| out_size | output | 2 | 0 byte, 1 half-word, 2 word, 3 unknown |

## Verification
The bench builds the block with its default parameters: a 21-bit address, an 8-bit relative offset and four targets. With those values every target slot can be reached, and a base stored just below 2^21 (or near zero) lets an 8-bit offset cross the wrap boundary in both directions. The vector table chains requests so that each history value is read back through a later relative or same-address request. This shows which commits stored their address and which did not, and it includes the commit that follows an unknown-size request. Directed steps then cover a break and a mid-run reset, again by reading the history back through the flag.

// File: rtl/ahr_pkg.sv
package ahr_pkg;
  typedef enum logic [1:0] {
    CMD_ABS  = 2'd0,
    CMD_REL  = 2'd1,
    CMD_SAME = 2'd2,
    CMD_SPR  = 2'd3
  } cmd_e;

  typedef enum logic [2:0] {
    RSP_ACK      = 3'd0,
    RSP_ACK_DATA = 3'd1,
    RSP_BUSY     = 3'd2,
    RSP_ERR_ADDR = 3'd3,
    RSP_ERR_CRC  = 3'd4
  } resp_e;

  typedef enum logic [1:0] {
    SZ_BYTE    = 2'd0,
    SZ_HALF    = 2'd1,
    SZ_WORD    = 2'd2,
    SZ_UNKNOWN = 2'd3
  } size_e;
endpackage

// File: rtl/ahr_hist.sv
module ahr_hist #(
  parameter int NUM_TGT = 4,
  parameter int ADDR_W  = 21,
  localparam int TID_W  = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              brk,
  input  logic [TID_W-1:0]  rd_tid,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_ok,
  input  logic              wr_en,
  input  logic [TID_W-1:0]  wr_tid,
  input  logic [ADDR_W-1:0] wr_addr
);
  logic [ADDR_W-1:0]  mem [NUM_TGT];
  logic [NUM_TGT-1:0] valid_q;

  // address storage carries no reset so it may map onto a RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_tid] <= wr_addr;
  end

  always_ff @(posedge clk) begin
    if (rst || brk) valid_q <= '0;
    else if (wr_en) valid_q[wr_tid] <= 1'b1;
  end

  assign rd_addr = mem[rd_tid];
  assign rd_ok   = valid_q[rd_tid];

  p_break_clears_r11: assert property (@(posedge clk) disable iff (rst)
    brk |=> (valid_q == '0));

  p_valid_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !brk) |=> $stable(valid_q));
endmodule

// File: rtl/ahr_calc.sv
module ahr_calc
  import ahr_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int REL_W  = 8
) (
  input  cmd_e              kind,
  input  logic [ADDR_W-1:0] raw,
  input  logic              neg,
  input  logic [ADDR_W-1:0] base,
  input  logic              base_ok,
  output logic [ADDR_W-1:0] addr,
  output logic              nobase
);
  localparam logic [ADDR_W-1:0] REL_SPAN = ADDR_W'(1) << REL_W;

  logic [ADDR_W-1:0] off;
  logic [ADDR_W-1:0] lo2;

  assign off = {{(ADDR_W-REL_W){1'b0}}, raw[REL_W-1:0]};
  assign lo2 = {{(ADDR_W-2){1'b0}}, raw[1:0]};

  always_comb begin
    nobase = 1'b0;
    addr   = raw;
    unique case (kind)
      CMD_REL: begin
        if (!base_ok) begin
          nobase = 1'b1;
          addr   = off;
        end else if (neg) begin
          addr = base - (REL_SPAN - off);
        end else begin
          addr = base + off;
        end
      end
      CMD_SAME: begin
        if (!base_ok) begin
          nobase = 1'b1;
          addr   = lo2;
        end else begin
          addr = {base[ADDR_W-1:2], raw[1:0]};
        end
      end
      default: addr = raw;
    endcase
  end
endmodule

// File: rtl/ahr_size.sv
module ahr_size
  import ahr_pkg::*;
#(
  parameter int ADDR_W = 21
) (
  input  logic              szb,
  input  logic [1:0]        raw_lo,
  input  logic [ADDR_W-1:0] addr_in,
  output size_e             size,
  output logic [ADDR_W-1:0] addr_out
);
  always_comb begin
    addr_out = addr_in;
    if (!szb) begin
      size = SZ_BYTE;
    end else if (raw_lo == 2'b01) begin
      size          = SZ_WORD;
      addr_out[1:0] = 2'b01;
    end else if (!raw_lo[0]) begin
      size        = SZ_HALF;
      addr_out[0] = 1'b0;
    end else begin
      size = SZ_UNKNOWN;
    end
  end
endmodule

// File: rtl/addr_hist_resolver.sv
module addr_hist_resolver
  import ahr_pkg::*;
#(
  parameter int NUM_TGT = 4,
  parameter int ADDR_W  = 21,
  parameter int REL_W   = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        brk_clr,
  input  logic                        req_valid,
  input  logic [$clog2(NUM_TGT)-1:0]  req_tid,
  input  logic [1:0]                  req_cmd,
  input  logic [ADDR_W-1:0]           req_raw,
  input  logic                        req_neg,
  input  logic                        req_szb,
  input  logic                        cmt_valid,
  input  logic                        cmt_crc_ok,
  input  logic [2:0]                  cmt_resp,
  output logic                        out_valid,
  output logic [ADDR_W-1:0]           out_addr,
  output logic                        out_nobase,
  output logic [1:0]                  out_size
);
  localparam int TID_W = $clog2(NUM_TGT);

  cmd_e              kind;
  logic [ADDR_W-1:0] base;
  logic              base_ok;
  logic [ADDR_W-1:0] calc_addr;
  logic              calc_nobase;
  size_e             calc_size;
  logic [ADDR_W-1:0] fin_addr;

  logic              pend_q;
  logic [TID_W-1:0]  pend_tid_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic              store;
  logic              resp_ack;

  assign kind     = cmd_e'(req_cmd);
  assign resp_ack = (resp_e'(cmt_resp) == RSP_ACK) || (resp_e'(cmt_resp) == RSP_ACK_DATA);
  assign store    = cmt_valid && cmt_crc_ok && resp_ack && pend_q && !brk_clr;

  ahr_hist #(.NUM_TGT(NUM_TGT), .ADDR_W(ADDR_W)) u_hist (
    .clk     (clk),
    .rst     (rst),
    .brk     (brk_clr),
    .rd_tid  (req_tid),
    .rd_addr (base),
    .rd_ok   (base_ok),
    .wr_en   (store),
    .wr_tid  (pend_tid_q),
    .wr_addr (pend_addr_q)
  );

  ahr_calc #(.ADDR_W(ADDR_W), .REL_W(REL_W)) u_calc (
    .kind    (kind),
    .raw     (req_raw),
    .neg     (req_neg),
    .base    (base),
    .base_ok (base_ok),
    .addr    (calc_addr),
    .nobase  (calc_nobase)
  );

  ahr_size #(.ADDR_W(ADDR_W)) u_size (
    .szb      (req_szb),
    .raw_lo   (req_raw[1:0]),
    .addr_in  (calc_addr),
    .size     (calc_size),
    .addr_out (fin_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_addr   <= '0;
      out_nobase <= 1'b0;
      out_size   <= 2'd0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        out_addr   <= fin_addr;
        out_nobase <= calc_nobase;
        out_size   <= calc_size;
      end
    end
  end

  // pending entry: the latest resolution awaiting its commit
  always_ff @(posedge clk) begin
    if (rst || brk_clr) begin
      pend_q      <= 1'b0;
      pend_tid_q  <= '0;
      pend_addr_q <= '0;
    end else if (req_valid) begin
      pend_q      <= (calc_size != SZ_UNKNOWN);
      pend_tid_q  <= req_tid;
      pend_addr_q <= fin_addr;
    end else if (cmt_valid) begin
      pend_q <= 1'b0;
    end
  end

  p_out_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> out_valid);

  p_out_idle_r12: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !out_valid);

  p_abs_no_flag_r1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (kind == CMD_ABS)) |=> !out_nobase);

  p_same_upper_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (kind == CMD_SAME) && base_ok)
      |=> (out_addr[ADDR_W-1:2] == $past(base[ADDR_W-1:2])));

  p_word_align_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && (out_size == SZ_WORD)) |-> (out_addr[1:0] == 2'b01));

  p_half_align_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && (out_size == SZ_HALF)) |-> !out_addr[0]);

  p_unknown_disarm_r10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && (out_size == SZ_UNKNOWN)) |-> !pend_q);
endmodule

// File: tb/tb_addr_hist_resolver.sv
`timescale 1ns/1ps
module tb_addr_hist_resolver;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        brk_clr = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_tid = '0;
  logic [1:0]  req_cmd = '0;
  logic [20:0] req_raw = '0;
  logic        req_neg = 1'b0;
  logic        req_szb = 1'b0;
  logic        cmt_valid = 1'b0;
  logic        cmt_crc_ok = 1'b0;
  logic [2:0]  cmt_resp = '0;
  logic        out_valid;
  logic [20:0] out_addr;
  logic        out_nobase;
  logic [1:0]  out_size;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  addr_hist_resolver dut (
    .clk(clk), .rst(rst), .brk_clr(brk_clr),
    .req_valid(req_valid), .req_tid(req_tid), .req_cmd(req_cmd),
    .req_raw(req_raw), .req_neg(req_neg), .req_szb(req_szb),
    .cmt_valid(cmt_valid), .cmt_crc_ok(cmt_crc_ok), .cmt_resp(cmt_resp),
    .out_valid(out_valid), .out_addr(out_addr),
    .out_nobase(out_nobase), .out_size(out_size)
  );

  typedef struct packed {
    logic [1:0]  tid;
    logic [1:0]  kind;
    logic [20:0] raw;
    logic        neg;
    logic        szb;
    logic        cmt;
    logic        crc;
    logic [2:0]  resp;
    logic [20:0] eaddr;
    logic        enb;
    logic [1:0]  esz;
    logic [3:0]  rq;
  } vec_t;

  // kind: 0 abs, 1 rel, 2 same; resp: 0 ack, 1 ack+data, 2 busy
  // size: 0 byte, 1 half, 2 word, 3 unknown
  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'd0, 21'h012344, 1'b0, 1'b1, 1'b1, 1'b1, 3'd0, 21'h012344, 1'b0, 2'd1, 4'd1},  // R1 R9
    '{2'd0, 2'd2, 21'h000001, 1'b0, 1'b1, 1'b1, 1'b1, 3'd2, 21'h012345, 1'b0, 2'd2, 4'd2},  // R2 R8, busy commit
    '{2'd0, 2'd1, 21'h000010, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 21'h012354, 1'b0, 2'd0, 4'd3},  // R3 R6 R7, bad crc
    '{2'd0, 2'd1, 21'h000010, 1'b1, 1'b0, 1'b1, 1'b1, 3'd1, 21'h012254, 1'b0, 2'd0, 4'd4},  // R4 R6
    '{2'd0, 2'd2, 21'h000002, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 21'h012256, 1'b0, 2'd1, 4'd6},  // R6 store seen
    '{2'd1, 2'd1, 21'h000005, 1'b0, 1'b0, 1'b1, 1'b1, 3'd0, 21'h000005, 1'b1, 2'd0, 4'd5},  // R5 R13
    '{2'd1, 2'd1, 21'h000003, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 21'h1FFF08, 1'b0, 2'd0, 4'd4},  // R4 wrap
    '{2'd2, 2'd0, 21'h1FFFFF, 1'b0, 1'b1, 1'b1, 1'b1, 3'd0, 21'h1FFFFF, 1'b0, 2'd3, 4'd10}, // R10
    '{2'd2, 2'd2, 21'h000001, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 21'h000001, 1'b1, 2'd0, 4'd10}, // R10 nothing stored
    '{2'd0, 2'd0, 21'h0ABCDE, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 21'h0ABCDE, 1'b0, 2'd1, 4'd9},  // R9
    '{2'd1, 2'd1, 21'h000001, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 21'h000005, 1'b0, 2'd2, 4'd8},  // R8 forcing
    '{2'd3, 2'd0, 21'h000003, 1'b0, 1'b0, 1'b1, 1'b1, 3'd0, 21'h000003, 1'b0, 2'd0, 4'd13}, // R13
    '{2'd3, 2'd1, 21'h0000FF, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 21'h000102, 1'b0, 2'd3, 4'd10}, // R10 unforced
    '{2'd2, 2'd0, 21'h1FFFF0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd0, 21'h1FFFF0, 1'b0, 2'd0, 4'd1},  // R1
    '{2'd2, 2'd1, 21'h000020, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 21'h000010, 1'b0, 2'd0, 4'd3}   // R3 wrap
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic request(input logic [1:0] tid, input logic [1:0] kind,
                         input logic [20:0] raw, input logic neg, input logic szb);
    @(negedge clk);
    req_valid = 1'b1; req_tid = tid; req_cmd = kind;
    req_raw = raw; req_neg = neg; req_szb = szb;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic commit(input logic crc, input logic [2:0] resp);
    cmt_valid = 1'b1; cmt_crc_ok = crc; cmt_resp = resp;
    @(negedge clk);
    cmt_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R12 reset out_valid", 32'(out_valid), 32'd0);
    check("R12 reset out_addr", 32'(out_addr), 32'd0);
    check("R12 reset out_nobase", 32'(out_nobase), 32'd0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VECS[i].rq, i);
      request(VECS[i].tid, VECS[i].kind, VECS[i].raw, VECS[i].neg, VECS[i].szb);
      check({tag, " valid"}, 32'(out_valid), 32'd1);
      check({tag, " addr"}, 32'(out_addr), 32'(VECS[i].eaddr));
      check({tag, " nobase"}, 32'(out_nobase), 32'(VECS[i].enb));
      check({tag, " size"}, 32'(out_size), 32'(VECS[i].esz));
      if (VECS[i].cmt) commit(VECS[i].crc, VECS[i].resp);
    end

    // R12: strobe drops after an idle cycle
    @(negedge clk);
    check("R12 idle out_valid", 32'(out_valid), 32'd0);

    // R11: break wipes every target (t0, t1, t3 hold bases here)
    @(negedge clk);
    brk_clr = 1'b1;
    @(negedge clk);
    brk_clr = 1'b0;
    request(2'd0, 2'd2, 21'h000000, 1'b0, 1'b0);
    check("R11 t0 nobase after break", 32'(out_nobase), 32'd1);
    check("R11 t0 addr after break", 32'(out_addr), 32'd0);
    request(2'd3, 2'd1, 21'h000007, 1'b0, 1'b0);
    check("R11 t3 nobase after break", 32'(out_nobase), 32'd1);
    check("R11 t3 addr after break", 32'(out_addr), 32'd7);

    // R12: reset also clears history
    request(2'd1, 2'd0, 21'h000100, 1'b0, 1'b0);
    commit(1'b1, 3'd1);
    request(2'd1, 2'd1, 21'h000004, 1'b0, 1'b0);
    check("R12 stored before reset", 32'(out_addr), 32'h104);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R12 out_valid after reset", 32'(out_valid), 32'd0);
    request(2'd1, 2'd1, 21'h000004, 1'b0, 1'b0);
    check("R12 nobase after reset", 32'(out_nobase), 32'd1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule